// File: doc/BRIEF.md
# I2C Master FIFO Level Flags and Interrupt Unit

This unit sits beside the command and receive FIFOs of an I2C master and turns their fill levels and the sequencer's bus events into one status word and one interrupt line. Software programs two watermarks. The transmit request flag stays up while the command FIFO has room at or below its watermark. The receive ready flag stays up while the receive FIFO holds more entries than its watermark.

Three bus events are latched as sticky flags: stop seen, NACK seen and arbitration lost. Software clears them by writing ones to their positions in the status register. Two live busy indications pass straight through. Each of four flags has its own interrupt enable. A control write can request a flush of either FIFO. The unit emits a one-cycle flush pulse that the FIFO logic consumes.

Top module: `fifo_flag_unit`

## Requirements
- R1: After reset the sticky flags, the interrupt enables and both watermarks are zero, and the flush outputs are low.
- R2: Status bit 0 (transmit request) is 1 exactly when `txCount` is less than or equal to the transmit watermark. The watermark is held in bits 1:0 of the FIFO control register at address 3.
- R3: Status bit 1 (receive ready) is 1 exactly when `rxCount` is greater than the receive watermark. The watermark is held in bits 17:16 of the FIFO control register at address 3.
- R4: A pulse on `evStop`, `evNack` or `evArbLost` sets status bit 9, 10 or 11 respectively from the next cycle on. The bit then stays set until it is cleared.
- R5: A write to address 1 clears each sticky flag whose bit in `wrData` is 1. Flags written with 0 keep their value.
- R6: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: Status bits 24 and 25 follow `masterBusy` and `busBusy` in the same cycle. Every status bit not named in R2 to R7 reads 0.
- R8: `irq` is the OR of each status bit at positions 0, 1, 9 and 10 ANDed with its enable at the same position of the register at address 2. Arbitration lost never raises `irq`.
- R9: `countWord` carries `txCount` in bits 7:0 and `rxCount` in bits 23:16. All other bits are 0.
- R10: A write to address 0 with bit 8 set raises `txFlush`, and one with bit 9 set raises `rxFlush`. Each pulse lasts exactly one cycle, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 status, 2 enables, 3 FIFO control |
| wrData | input | 32 | Write data |
| txCount | input | 3 | Command FIFO entry count (0..4) |
| rxCount | input | 3 | Receive FIFO entry count (0..4) |
| evStop | input | 1 | Stop-detected pulse |
| evNack | input | 1 | NACK-detected pulse |
| evArbLost | input | 1 | Arbitration-lost pulse |
| masterBusy | input | 1 | Master busy, live |
| busBusy | input | 1 | Bus busy, live |
| statusWord | output | 32 | Status word |
| countWord | output | 32 | FIFO count readback |
| irq | output | 1 | Masked interrupt |
| txFlush | output | 1 | Command FIFO flush pulse |
| rxFlush | output | 1 | Receive FIFO flush pulse |

## Verification
The critical overlap is a sequencer event arriving in the same cycle as a software write-one-to-clear of the same sticky flag. The bench forces this directly with a NACK pulse and a clearing write in one cycle, and expects the flag to survive. Random traffic makes such overlaps often, on all three flags. A second overlap is a watermark write in the same cycle that the counts change. The reference model judges it, because the new watermark applies only from the next cycle.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  localparam int DataW = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_IEN  = 2'd2,
    REG_FCTL = 2'd3
  } reg_sel_e;

  // bit positions decoded by neighbouring logic
  localparam int BitTxReq   = 0;
  localparam int BitRxRdy   = 1;
  localparam int BitStop    = 9;
  localparam int BitNack    = 10;
  localparam int BitArb     = 11;
  localparam int BitMBusy   = 24;
  localparam int BitBBusy   = 25;
  localparam int BitFlushTx = 8;
  localparam int BitFlushRx = 9;
  localparam int RxWmLsb    = 16;
  localparam int RxCntLsb   = 16;

  typedef struct packed {
    logic       enWr;
    logic       wmWr;
    logic [2:0] clrMask;  // stop, nack, arb
    logic       flushTx;
    logic       flushRx;
  } strobe_t;
endpackage

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl
  import fifo_flag_pkg::*;
(
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [DataW-1:0] wrData,
  output strobe_t          strobes
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wrAddr);

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (sel)
        REG_CTRL: begin
          strobes.flushTx = wrData[BitFlushTx];
          strobes.flushRx = wrData[BitFlushRx];
        end
        REG_STAT: strobes.clrMask = {wrData[BitArb], wrData[BitNack], wrData[BitStop]};
        REG_IEN:  strobes.enWr = 1'b1;
        REG_FCTL: strobes.wmWr = 1'b1;
        default:  strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/fifo_flag_dp.sv
module fifo_flag_dp
  import fifo_flag_pkg::*;
#(
  parameter int Depth = 4,
  localparam int CntW = $clog2(Depth + 1),
  localparam int WmW  = $clog2(Depth)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [DataW-1:0] wrData,
  input  logic [CntW-1:0]  txCount,
  input  logic [CntW-1:0]  rxCount,
  input  logic             evStop,
  input  logic             evNack,
  input  logic             evArbLost,
  input  logic             masterBusy,
  input  logic             busBusy,
  output logic [DataW-1:0] statusWord,
  output logic [DataW-1:0] countWord,
  output logic             irq,
  output logic             txFlush,
  output logic             rxFlush
);
  logic [WmW-1:0] txWm, rxWm;
  logic [3:0]     ienReg;   // nack, stop, rxRdy, txReq
  logic [2:0]     stickyQ;  // arb, nack, stop
  logic [2:0]     evVec;

  assign evVec = {evArbLost, evNack, evStop};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWm    <= '0;
      rxWm    <= '0;
      ienReg  <= '0;
      stickyQ <= '0;
      txFlush <= 1'b0;
      rxFlush <= 1'b0;
    end else begin
      if (strobes.wmWr) begin
        txWm <= wrData[WmW-1:0];
        rxWm <= wrData[RxWmLsb +: WmW];
      end
      if (strobes.enWr)
        ienReg <= {wrData[BitNack], wrData[BitStop], wrData[BitRxRdy], wrData[BitTxReq]};
      // a new event outranks a clear in the same cycle
      stickyQ <= evVec | (stickyQ & ~strobes.clrMask);
      txFlush <= strobes.flushTx;
      rxFlush <= strobes.flushRx;
    end
  end

  logic txReq, rxRdy;
  assign txReq = txCount <= CntW'(txWm);
  assign rxRdy = rxCount >  CntW'(rxWm);

  always_comb begin
    statusWord           = '0;
    statusWord[BitTxReq] = txReq;
    statusWord[BitRxRdy] = rxRdy;
    statusWord[BitStop]  = stickyQ[0];
    statusWord[BitNack]  = stickyQ[1];
    statusWord[BitArb]   = stickyQ[2];
    statusWord[BitMBusy] = masterBusy;
    statusWord[BitBBusy] = busBusy;
  end

  always_comb begin
    countWord                     = '0;
    countWord[CntW-1:0]           = txCount;
    countWord[RxCntLsb +: CntW]   = rxCount;
  end

  assign irq = |({stickyQ[1], stickyQ[0], rxRdy, txReq} & ienReg);
endmodule

// File: rtl/fifo_flag_unit.sv
module fifo_flag_unit
  import fifo_flag_pkg::*;
#(
  parameter int Depth = 4,
  localparam int CntW = $clog2(Depth + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [CntW-1:0]  txCount,
  input  logic [CntW-1:0]  rxCount,
  input  logic             evStop,
  input  logic             evNack,
  input  logic             evArbLost,
  input  logic             masterBusy,
  input  logic             busBusy,
  output logic [DataW-1:0] statusWord,
  output logic [DataW-1:0] countWord,
  output logic             irq,
  output logic             txFlush,
  output logic             rxFlush
);
  strobe_t strobes;

  fifo_flag_ctrl i_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strobes(strobes)
  );

  fifo_flag_dp #(.Depth(Depth)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .txCount(txCount), .rxCount(rxCount),
    .evStop(evStop), .evNack(evNack), .evArbLost(evArbLost),
    .masterBusy(masterBusy), .busBusy(busBusy),
    .statusWord(statusWord), .countWord(countWord), .irq(irq),
    .txFlush(txFlush), .rxFlush(rxFlush)
  );
endmodule

// File: rtl/fifo_flag_chk.sv
module fifo_flag_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic [31:0] wrData,
  input logic        evStop,
  input logic        evNack,
  input logic [31:0] statusWord,
  input logic        irq,
  input logic        txFlush,
  input logic        rxFlush
);
  // R4
  stop_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> statusWord[9]);

  // R5
  stop_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd1 && wrData[9] && !evStop) |=> !statusWord[9]);

  // R6
  nack_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evNack && wrEn && wrAddr == 2'd1 && wrData[10]) |=> statusWord[10]);

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusWord[0] || statusWord[1] || statusWord[9] || statusWord[10]));

  // R10
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0 && wrData[8]) |=> txFlush);

  // R10
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlush && !(wrEn && wrAddr == 2'd0 && wrData[9])) |=> !rxFlush);
endmodule

bind fifo_flag_unit fifo_flag_chk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .evStop(evStop), .evNack(evNack), .statusWord(statusWord), .irq(irq),
  .txFlush(txFlush), .rxFlush(rxFlush)
);

// File: tb/test_fifo_flag_unit.sv
`timescale 1ns/1ps
module test_fifo_flag_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  txCount = '0, rxCount = '0;
  logic        evStop = 1'b0, evNack = 1'b0, evArbLost = 1'b0;
  logic        masterBusy = 1'b0, busBusy = 1'b0;
  logic [31:0] statusWord, countWord;
  logic        irq, txFlush, rxFlush;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fifo_flag_unit i_fifo_flag_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txCount(txCount), .rxCount(rxCount), .evStop(evStop), .evNack(evNack),
    .evArbLost(evArbLost), .masterBusy(masterBusy), .busBusy(busBusy),
    .statusWord(statusWord), .countWord(countWord), .irq(irq),
    .txFlush(txFlush), .rxFlush(rxFlush)
  );

  // behavioural reference state
  int mTxWm, mRxWm;
  bit mStop, mNack, mArb, mTxFl, mRxFl;
  bit mEn[4];  // enables for bits 0,1,9,10

  always @(posedge clk) begin
    if (!rstN) begin
      mTxWm = 0; mRxWm = 0; mStop = 0; mNack = 0; mArb = 0;
      mTxFl = 0; mRxFl = 0;
      foreach (mEn[i]) mEn[i] = 0;
    end else begin
      bit clrS, clrN, clrA;
      clrS = wrEn && wrAddr == 1 && wrData[9];
      clrN = wrEn && wrAddr == 1 && wrData[10];
      clrA = wrEn && wrAddr == 1 && wrData[11];
      mStop = evStop    ? 1 : (clrS ? 0 : mStop);
      mNack = evNack    ? 1 : (clrN ? 0 : mNack);
      mArb  = evArbLost ? 1 : (clrA ? 0 : mArb);
      mTxFl = wrEn && wrAddr == 0 && wrData[8];
      mRxFl = wrEn && wrAddr == 0 && wrData[9];
      if (wrEn && wrAddr == 2) begin
        mEn[0] = wrData[0]; mEn[1] = wrData[1];
        mEn[2] = wrData[9]; mEn[3] = wrData[10];
      end
      if (wrEn && wrAddr == 3) begin
        mTxWm = wrData[1:0];
        mRxWm = wrData[17:16];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit tq, rr, eIrq;
    logic [31:0] expCnt;
    tq = int'(txCount) <= mTxWm;
    rr = int'(rxCount) > mRxWm;
    chk(statusWord[0] == tq, "R2 txReq", {31'b0, statusWord[0]}, {31'b0, tq});
    chk(statusWord[1] == rr, "R3 rxRdy", {31'b0, statusWord[1]}, {31'b0, rr});
    chk(statusWord[11:9] == {mArb, mNack, mStop}, "R4 sticky",
        {29'b0, statusWord[11:9]}, {29'b0, mArb, mNack, mStop});
    chk(statusWord[25:24] == {busBusy, masterBusy} &&
        (statusWord & ~32'h0300_0E03) == 0, "R7 busy/unused",
        statusWord, {6'b0, busBusy, masterBusy, 24'b0});
    eIrq = (tq && mEn[0]) || (rr && mEn[1]) || (mStop && mEn[2]) || (mNack && mEn[3]);
    chk(irq == eIrq, "R8 irq", {31'b0, irq}, {31'b0, eIrq});
    expCnt = {8'b0, 5'b0, rxCount, 8'b0, 5'b0, txCount};
    chk(countWord == expCnt, "R9 count", countWord, expCnt);
    chk(txFlush == mTxFl && rxFlush == mRxFl, "R10 flush",
        {30'b0, rxFlush, txFlush}, {30'b0, mRxFl, mTxFl});
  endtask

  task automatic idle();
    wrEn = 0; evStop = 0; evNack = 0; evArbLost = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wrEn = 1; wrAddr = 2'(a); wrData = d;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk(statusWord[11:9] == 0 && !txFlush && !rxFlush, "R1 reset",
        statusWord, 32'h1);
    chk(statusWord[0] == 1 && statusWord[1] == 0 && irq == 0, "R1 wm/en zero",
        {30'b0, irq, statusWord[0]}, 32'h1);

    // R2 R3 sweep watermarks and counts
    for (int w = 0; w < 4; w++) begin
      wr(3, 32'(w) | (32'(3 - w) << 16));
      tick();
      for (int c = 0; c <= 4; c++) begin
        txCount = 3'(c); rxCount = 3'(4 - c);
        tick();
      end
    end

    // R4 events, R5 clear one at a time
    evStop = 1; evNack = 1; evArbLost = 1; tick();
    tick();
    chk(statusWord[11:9] == 3'b111, "R4 all set", statusWord, 32'h0E00);
    wr(1, 32'h0000_0400); tick();
    chk(statusWord[11:9] == 3'b101, "R5 nack cleared only", statusWord, 32'h0A00);
    wr(1, 32'h0000_7F00); tick();
    chk(statusWord[11:9] == 3'b000, "R5 all cleared", statusWord, 32'h0);

    // R6 collision
    evNack = 1; wr(1, 32'h0000_0400); tick();
    chk(statusWord[10] == 1, "R6 set wins", statusWord, 32'h0400);
    wr(1, 32'h0000_0E00); tick();

    // R7 busy
    masterBusy = 1; busBusy = 0; tick();
    masterBusy = 0; busBusy = 1; tick();
    busBusy = 0;

    // R8 enables, arb lost cannot interrupt
    txCount = 4; rxCount = 0; wr(3, 0); tick();
    wr(2, 32'h0000_0800); evArbLost = 1; tick();
    tick();
    chk(irq == 0, "R8 arb no irq", {31'b0, irq}, 32'h0);
    wr(2, 32'h0000_0600); evStop = 1; tick();
    tick();
    chk(irq == 1, "R8 stop irq", {31'b0, irq}, 32'h1);
    wr(1, 32'h0000_0E00); tick();
    wr(2, 32'h0000_0003); tick();
    txCount = 0; tick();

    // R10 flush pulses
    wr(0, 32'h0000_0100); tick();
    chk(txFlush == 1 && rxFlush == 0, "R10 tx pulse", {30'b0, rxFlush, txFlush}, 32'h1);
    wr(0, 32'h0000_0200); tick();
    chk(txFlush == 0 && rxFlush == 1, "R10 rx pulse", {30'b0, rxFlush, txFlush}, 32'h2);
    tick();
    chk(txFlush == 0 && rxFlush == 0, "R10 one cycle", {30'b0, rxFlush, txFlush}, 32'h0);

    // random traffic with collisions
    for (int n = 0; n < 3000; n++) begin
      txCount = 3'($urandom_range(4));
      rxCount = 3'($urandom_range(4));
      masterBusy = 1'($urandom);
      busBusy = 1'($urandom);
      evStop = ($urandom_range(9) == 0);
      evNack = ($urandom_range(9) == 0);
      evArbLost = ($urandom_range(9) == 0);
      if ($urandom_range(3) == 0) wr(int'($urandom_range(3)), $urandom);
      @(negedge clk);
      compare_all();
      idle();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule